// File: doc/BRIEF.md
# Binary versus one-hot state machine lockstep checker

This block runs two independent implementations of one four-state Moore machine on the same clock, reset and single-bit input `x`. One implementation stores its state in two binary-coded flip-flops. The other stores it in four one-hot flip-flops. Every cycle a comparator checks the two machines' output bits against each other.

The block reports both outputs and both state vectors. It also reports a registered `equal` flag, which stays high while the machines agree, and a sticky `mismatch` alarm. A cycle counter records the cycle in which the first disagreement appeared. A test-only `fault_inject` input corrupts one next-state bit of the binary machine. This gives a bench a way to show that the comparator catches a divergence. The block is used in simulation to confirm, in lockstep, that a re-encoded machine behaves the same as its original.

The four abstract states are named S0, S1, S2 and S3. The output is 1 only in S3. The transitions are:
- S0 goes to S1 on x=0 and to S2 on x=1.
- S1 stays in S1 on x=0 and goes to S3 on x=1.
- S2 stays in S2 for either value of x.
- S3 returns to S0 for either value of x.

Top module: `fsm_miter`

## Requirements
- R1: Reset is synchronous and active high. The clock edge that sees `rst`=1 puts both machines in S0, sets `equal` to 1, clears `mismatch` and sets `mismatch_cycle` to 0.
- R2: `state_hot` is {a,b,c,d} with a in bit 3. S0=1000, S1=0100, S2=0010 and S3=0001. It follows the transition table on every clock edge.
- R3: `state_bin` is {p,q} with p in bit 1. S0=00, S1=01, S2=11 and S3=10. When `fault_inject` is 0, it follows the same transition table.
- R4: `z_bin` equals p AND NOT q. `z_hot` equals d. Each output is therefore 1 only in S3.
- R5: `equal` is registered. In cycle k+1 it is 1 exactly when `z_bin` equaled `z_hot` in cycle k.
- R6: `mismatch` goes high on the first clock edge at which `z_bin` and `z_hot` differ. It stays high, even after the machines agree again, until reset.
- R7: `mismatch_cycle` holds the index of the first cycle in which the outputs differed. The cycle right after reset is index 0. The internal cycle counter saturates at its maximum value.
- R8: While `fault_inject` is 1, the q bit of the binary machine's next state is forced to 0 and p follows the table. The one-hot machine is not affected.
- R9: With `fault_inject` held at 0 since reset, `equal` stays 1 and `mismatch` stays 0 for every sequence of x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Machine input shared by both implementations |
| fault_inject | input | 1 | Test-only input; forces the binary q next-state bit to 0 |
| z_bin | output | 1 | Output of the binary-coded machine |
| z_hot | output | 1 | Output of the one-hot machine |
| state_bin | output | 2 | Binary state {p,q} |
| state_hot | output | 4 | One-hot state {a,b,c,d} |
| equal | output | 1 | Registered result of comparing the two outputs |
| mismatch | output | 1 | Sticky disagreement alarm |
| mismatch_cycle | output | CYC_W | Cycle index of the first disagreement |

## Verification
A wrong binary next-state bit does not always show at the outputs at once. From S0 with x=0, a lost q bit leaves the binary machine in S0 while the one-hot machine is in S1, and both outputs are still 0. The divergence only reaches `z_bin` or `z_hot` when one machine enters S3 and the other does not. `equal` and `mismatch` then report it one edge later. Because of this, the bench compares both state vectors directly every cycle, so that a corrupted state is caught in the cycle after it is written. It also tracks the output, alarm and captured cycle index against an independent model of the table.

// File: rtl/miter_pkg.sv
package miter_pkg;

    typedef enum logic [1:0] {
        ST_S0 = 2'd0,
        ST_S1 = 2'd1,
        ST_S2 = 2'd2,
        ST_S3 = 2'd3
    } abs_state_e;

    typedef struct packed {
        logic p;
        logic q;
    } bin_state_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } hot_state_t;

    localparam bin_state_t BIN_RESET = '{p: 1'b0, q: 1'b0};
    localparam hot_state_t HOT_RESET = '{a: 1'b1, b: 1'b0, c: 1'b0, d: 1'b0};

    function automatic bin_state_t bin_next(input bin_state_t s, input logic x);
        bin_state_t n;
        n.p = (s.p & s.q) | (s.q & x) | (~s.p & x);
        n.q = (~s.p) | (s.p & s.q);
        if (s.p & ~s.q) begin
            n.q = 1'b0;
        end else if (~s.p & s.q & x) begin
            n.q = 1'b0;
        end
        return n;
    endfunction

    function automatic hot_state_t hot_next(input hot_state_t s, input logic x);
        hot_state_t n;
        n.a = s.d;
        n.b = (s.a | s.b) & ~x;
        n.c = (s.a & x) | s.c;
        n.d = s.b & x;
        return n;
    endfunction

endpackage

// File: rtl/bin_fsm.sv
module bin_fsm
    import miter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       x,
    input  logic       force_q_low,
    output bin_state_t state,
    output logic       z
);
    bin_state_t nxt;

    always_comb begin
        nxt = bin_next(state, x);
        if (force_q_low) begin
            nxt.q = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BIN_RESET;
        end else begin
            state <= nxt;
        end
    end

    assign z = state.p & ~state.q;

    // R3: S3 (10) always returns to S0 (00)
    assert_s3_to_s0_R3: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10) |=> (state == 2'b00));

    // R3: S2 (11) holds when no fault is injected
    assert_s2_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((state == 2'b11) && !force_q_low) |=> (state == 2'b11));
endmodule

// File: rtl/hot_fsm.sv
module hot_fsm
    import miter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       x,
    output hot_state_t state,
    output logic       z
);
    hot_state_t nxt;

    always_comb begin
        nxt = hot_next(state, x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HOT_RESET;
        end else begin
            state <= nxt;
        end
    end

    assign z = state.d;

    // R2: exactly one state bit is set in every cycle after reset
    assert_one_hot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    // R2: S2 is absorbing
    assert_s2_hold_R2: assert property (@(posedge clk) disable iff (rst)
        state.c |=> state.c);
endmodule

// File: rtl/out_compare.sv
module out_compare #(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             z_a,
    input  logic             z_b,
    output logic             equal,
    output logic             mismatch,
    output logic [CYC_W-1:0] mismatch_cycle
);
    localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

    logic [CYC_W-1:0] cyc;
    logic             differ;

    assign differ = z_a ^ z_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc            <= '0;
            equal          <= 1'b1;
            mismatch       <= 1'b0;
            mismatch_cycle <= '0;
        end else begin
            if (cyc != CYC_MAX) begin
                cyc <= cyc + 1'b1;
            end
            equal <= ~differ;
            if (differ && !mismatch) begin
                mismatch       <= 1'b1;
                mismatch_cycle <= cyc;
            end
        end
    end

    // R6: alarm is sticky
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> mismatch);

    // R5: a disagreement drops equal on the next cycle
    assert_equal_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (z_a != z_b) |=> !equal);

    // R7: captured index never changes once the alarm is up
    assert_cycle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> $stable(mismatch_cycle));
endmodule

// File: rtl/fsm_miter.sv
module fsm_miter
    import miter_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             x,
    input  logic             fault_inject,
    output logic             z_bin,
    output logic             z_hot,
    output logic [1:0]       state_bin,
    output logic [3:0]       state_hot,
    output logic             equal,
    output logic             mismatch,
    output logic [CYC_W-1:0] mismatch_cycle
);
    bin_state_t bst;
    hot_state_t hst;

    bin_fsm u_bin (
        .clk         (clk),
        .rst         (rst),
        .x           (x),
        .force_q_low (fault_inject),
        .state       (bst),
        .z           (z_bin)
    );

    hot_fsm u_hot (
        .clk   (clk),
        .rst   (rst),
        .x     (x),
        .state (hst),
        .z     (z_hot)
    );

    out_compare #(.CYC_W(CYC_W)) u_cmp (
        .clk            (clk),
        .rst            (rst),
        .z_a            (z_bin),
        .z_b            (z_hot),
        .equal          (equal),
        .mismatch       (mismatch),
        .mismatch_cycle (mismatch_cycle)
    );

    assign state_bin = bst;
    assign state_hot = hst;

    // R4: each output is high only in its encoding of S3
    assert_z_decode_R4: assert property (@(posedge clk) disable iff (rst)
        (z_hot == (state_hot == 4'b0001)) && (z_bin == (state_bin == 2'b10)));
endmodule

// File: tb/tb_fsm_miter.sv
module tb_fsm_miter;
    localparam int CYC_W = 16;

    typedef struct {
        int         req;
        logic [1:0] sb;
        logic [3:0] sh;
        logic       zb;
        logic       zh;
        logic       eq;
        logic       mis;
        logic [CYC_W-1:0] mc;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x = 1'b0;
    logic fault_inject = 1'b0;
    logic z_bin, z_hot, equal, mismatch;
    logic [1:0] state_bin;
    logic [3:0] state_hot;
    logic [CYC_W-1:0] mismatch_cycle;

    int n_checks = 0;
    int n_fail = 0;
    exp_t sbq[$];

    // independent model
    int         m_spec;     // abstract state 0..3 of the one-hot machine
    logic [1:0] m_bin;      // binary machine code, fault applied
    logic       m_eq, m_mis;
    logic [CYC_W-1:0] m_mc, m_cyc;

    always #10 clk = ~clk;  // 50 MHz

    fsm_miter #(.CYC_W(CYC_W)) dut (
        .clk(clk), .rst(rst), .x(x), .fault_inject(fault_inject),
        .z_bin(z_bin), .z_hot(z_hot), .state_bin(state_bin),
        .state_hot(state_hot), .equal(equal), .mismatch(mismatch),
        .mismatch_cycle(mismatch_cycle)
    );

    function automatic int spec_next(int s, logic xi);
        case (s)
            0: return xi ? 2 : 1;
            1: return xi ? 3 : 1;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] enc_bin(int s);
        case (s)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic int dec_bin(logic [1:0] c);
        case (c)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [3:0] enc_hot(int s);
        return 4'b1000 >> s;
    endfunction

    function automatic exp_t snap(int req);
        exp_t e;
        e.req = req;
        e.sb  = m_bin;
        e.sh  = enc_hot(m_spec);
        e.zb  = (m_bin == 2'b10);
        e.zh  = (m_spec == 3);
        e.eq  = m_eq;
        e.mis = m_mis;
        e.mc  = m_mc;
        return e;
    endfunction

    // R1 reset step
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x = 1'b0;
        fault_inject = 1'b0;
        m_spec = 0; m_bin = 2'b00; m_eq = 1'b1; m_mis = 1'b0;
        m_mc = '0; m_cyc = '0;
        @(posedge clk);
        sbq.push_back(snap(1));
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(logic xi, logic fi, int req);
        logic differ;
        logic [1:0] nb;
        if (clk) @(negedge clk);
        x = xi;
        fault_inject = fi;
        differ = (m_bin == 2'b10) != (m_spec == 3);
        nb = enc_bin(spec_next(dec_bin(m_bin), xi));
        if (fi) nb[0] = 1'b0;       // R8: q forced low
        m_bin = nb;
        m_spec = spec_next(m_spec, xi);
        m_eq = !differ;             // R5
        if (differ && !m_mis) begin // R6, R7
            m_mis = 1'b1;
            m_mc = m_cyc;
        end
        if (m_cyc != '1) m_cyc = m_cyc + 1'b1;
        @(posedge clk);
        sbq.push_back(snap(req));
        @(negedge clk);
    endtask

    task automatic chk(int req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compare outputs away from the active edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.req == 1 ? 1 : 3, "state_bin", {30'd0, state_bin}, {30'd0, e.sb});
            chk(e.req == 1 ? 1 : 2, "state_hot", {28'd0, state_hot}, {28'd0, e.sh});
            chk(e.req == 1 ? 1 : 4, "z_bin", {31'd0, z_bin}, {31'd0, e.zb});
            chk(e.req == 1 ? 1 : 4, "z_hot", {31'd0, z_hot}, {31'd0, e.zh});
            chk(e.req == 1 ? 1 : (e.req == 9 ? 9 : 5), "equal", {31'd0, equal}, {31'd0, e.eq});
            chk(e.req == 1 ? 1 : (e.req == 9 ? 9 : 6), "mismatch", {31'd0, mismatch}, {31'd0, e.mis});
            chk(e.req == 1 ? 1 : 7, "mismatch_cycle", {16'd0, mismatch_cycle}, {16'd0, e.mc});
        end
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();  // R1
        // R9, R2, R3: exhaustive x sequences of length 4 from reset
        for (int v = 0; v < 16; v++) begin
            do_reset();
            for (int i = 0; i < 4; i++) step(v[i], 1'b0, 9);
        end
        // R9: long random run without faults, periodic resets
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) do_reset();
            step(1'(($urandom >> 3) & 1), 1'b0, 9);
        end
        // R8, R6, R7: fault from S0 with x=0 keeps binary in S0; x=1 then splits outputs
        do_reset();
        step(1'b0, 1'b1, 8);
        step(1'b1, 1'b0, 8);
        step(1'b0, 1'b0, 6);
        step(1'b0, 1'b0, 6);   // R6: alarm holds after outputs realign
        step(1'b1, 1'b0, 7);
        // R8: fault from S0 with x=1 lands binary in S3
        do_reset();
        step(1'b0, 1'b0, 8);
        step(1'b0, 1'b0, 8);
        do_reset();
        step(1'b1, 1'b1, 8);
        step(1'b0, 1'b0, 7);
        step(1'b1, 1'b0, 7);
        do_reset();            // R1: alarm cleared
        // random with sparse faults
        for (int i = 0; i < 400; i++) begin
            if (i % 40 == 0) do_reset();
            step(1'($urandom & 1), 1'(($urandom % 7) == 0), 8);
        end
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule